// File: doc/BRIEF.md
# Multifunction Integer ALU with Barrel Shifter

This block is the combinational arithmetic and logic unit of a 32-bit load/store datapath. It takes two operands, `x` (the first register source) and `y` (the second register source or an extended immediate), and forms one result. A two-bit class code steers the result from one of four units: a barrel shifter, a signed set-on-less-than unit, an adder/subtractor, or a bitwise logic unit. Three further fields refine each class: the add/subtract select, the logic function and the shift function.

The shifter always moves `y`. Its amount comes either from a 5-bit constant field of the instruction or from the low five bits of `x`. Placing an immediate in the upper half of a word uses the same shifter: a constant left shift of 16 applied to `y`. Two flags go with every result. `zero` is a wide NOR of the result bits. `ovfl` reports signed overflow of the adder/subtractor, whatever class is selected.

Top module: `alu_core`

## Requirements
- R1: `fclass` picks the result source: 2'b00 shifter, 2'b01 set-less-than, 2'b10 adder/subtractor, 2'b11 logic unit.
- R2: With `sub_sel`=0 the adder result is `x`+`y`. With `sub_sel`=1 it is `x`-`y`, formed as `x` + ~`y` + 1. Both wrap modulo 2^32.
- R3: `ovfl` is 1 exactly when the signed adder/subtractor result under the current `sub_sel` does not fit in 32 bits. This holds for every value of `fclass`.
- R4: `logic_fn` selects 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR of `x` and `y`.
- R5: `shift_fn` applied to `y` selects 2'b00 pass-through, 2'b01 logical left (zero fill), 2'b10 logical right (zero fill), 2'b11 arithmetic right (copies of `y[31]`), for every amount from 0 to 31.
- R6: With `amt_var`=0 the shift amount is `shamt_k`. With `amt_var`=1 it is `x[4:0]`. The unselected source and the upper bits of `x` have no effect on the shift.
- R7: With `sub_sel`=1, the set-less-than class gives 32'h1 when `x` < `y` as signed numbers and 32'h0 otherwise. The answer stays correct when `x`-`y` overflows.
- R8: `zero` is 1 exactly when all 32 result bits are 0, in every class.
- R9: A constant left shift of 16 places `y[15:0]` in result bits 31:16 and clears bits 15:0, whatever the upper half of `y` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 32 | First operand; its low 5 bits also serve as a variable shift amount |
| y | input | 32 | Second operand; the value that is shifted |
| shamt_k | input | 5 | Constant shift amount from the instruction field |
| amt_var | input | 1 | Shift amount source: 0 constant, 1 from `x[4:0]` |
| fclass | input | 2 | Result class select |
| sub_sel | input | 1 | Adder mode: 0 add, 1 subtract |
| logic_fn | input | 2 | Bitwise function select |
| shift_fn | input | 2 | Shift kind select |
| result | output | 32 | Selected unit output |
| zero | output | 1 | All result bits are zero |
| ovfl | output | 1 | Signed overflow of the adder/subtractor |

## Verification
The bench aims at signed comparisons whose difference overflows, such as the most negative value against 1 and the most positive value against -1. A design that took the raw difference sign would invert the answer in those cases. Shifts are swept over all 32 amounts in all three directions on an operand with its top bit set. This catches a zero-filled arithmetic shift, a sign-filled logical shift, or a wrong stage weight in the barrel. Operands whose upper bits are nonzero and a constant field set to a different amount show whether the amount mux reads the wrong source or too many bits of `x`. Overflow is checked while the logic class is selected, which exposes a flag gated by class.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Result class codes; the encoding is decoded by the instruction control.
    typedef enum logic [1:0] {
        FC_SHIFT = 2'b00,
        FC_SLT   = 2'b01,
        FC_ARITH = 2'b10,
        FC_LOGIC = 2'b11
    } fclass_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_fn_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_ARITH = 2'b11
    } shift_fn_e;

    // Flags leaving the adder that other units consume.
    typedef struct packed {
        logic msb;
        logic ovfl;
    } add_flags_t;

    // Two operands of equal sign giving a sum of the other sign.
    function automatic logic signed_ovfl(input logic a_msb,
                                         input logic b_msb,
                                         input logic s_msb);
        return (a_msb == b_msb) && (s_msb != a_msb);
    endfunction

    // True sign of a difference, corrected for overflow.
    function automatic logic true_less(input add_flags_t f);
        return f.msb ^ f.ovfl;
    endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    input  shift_fn_e        fn,
    output logic [WIDTH-1:0] dout
);

    logic             go_left;
    logic             fill;
    logic [AMT_W-1:0] amt_eff;
    logic [WIDTH-1:0] din_rev;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] core_rev;
    logic [WIDTH-1:0] stg [AMT_W+1];

    assign go_left = (fn == SH_LEFT);
    assign fill    = (fn == SH_ARITH) & din[WIDTH-1];
    assign amt_eff = (fn == SH_NONE) ? '0 : amt;

    // Left shifts reuse the right-shift barrel on bit-reversed data.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign din_rev[i]  = din[WIDTH-1-i];
        assign core_rev[i] = core_out[WIDTH-1-i];
    end

    assign core_in = go_left ? din_rev : din;
    assign stg[0]  = core_in;

    // One stage per amount bit, stage k moving by 2**k places.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = amt_eff[k] ? {{D{fill}}, stg[k][WIDTH-1:D]} : stg[k];
    end

    assign core_out = stg[AMT_W];
    assign dout     = go_left ? core_rev : core_out;

    always_comb begin
        // R5: an arithmetic right shift keeps the operand sign
        a_r5_sign_kept: assert (!(fn == SH_ARITH) || (dout[WIDTH-1] == din[WIDTH-1]))
            else $error("arithmetic shift lost the sign bit");
        // R5: a nonzero left shift clears the bottom bit
        a_r5_left_fill: assert (!(fn == SH_LEFT && amt != '0) || !dout[0])
            else $error("left shift did not zero-fill");
        // R5: a nonzero logical right shift clears the top bit
        a_r5_right_fill: assert (!(fn == SH_RIGHT && amt != '0) || !dout[WIDTH-1])
            else $error("logical right shift did not zero-fill");
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output add_flags_t       flags
);

    logic [WIDTH-1:0] b_eff;

    // Subtraction: invert the second operand and carry one in.
    assign b_eff      = b ^ {WIDTH{sub}};
    assign sum        = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
    assign flags.msb  = sum[WIDTH-1];
    assign flags.ovfl = signed_ovfl(a[WIDTH-1], b_eff[WIDTH-1], sum[WIDTH-1]);

    always_comb begin
        // R3: operands of differing effective sign can never overflow
        a_r3_no_overflow: assert (!(a[WIDTH-1] != b_eff[WIDTH-1]) || !flags.ovfl)
            else $error("overflow flagged on mixed-sign operands");
        // R3: an overflow always flips the sign away from the first operand
        a_r3_sign_flip: assert (!flags.ovfl || (sum[WIDTH-1] != a[WIDTH-1]))
            else $error("overflow without sign change");
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        unique case (fn)
            LG_AND:  dout = a & b;
            LG_OR:   dout = a | b;
            LG_XOR:  dout = a ^ b;
            LG_NOR:  dout = ~(a | b);
            default: dout = '0;
        endcase
    end

    always_comb begin
        // R4: NOR output has no bit in common with either operand
        a_r4_nor_disjoint: assert (!(fn == LG_NOR) || ((dout & (a | b)) == '0))
            else $error("NOR overlaps operands");
        // R4: AND output is contained in both operands
        a_r4_and_subset: assert (!(fn == LG_AND) || ((dout & ~(a & b)) == '0))
            else $error("AND sets bits outside operands");
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [AMT_W-1:0] shamt_k,
    input  logic             amt_var,
    input  logic [1:0]       fclass,
    input  logic             sub_sel,
    input  logic [1:0]       logic_fn,
    input  logic [1:0]       shift_fn,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovfl
);

    fclass_e          cls;
    logic [AMT_W-1:0] amt;
    logic [WIDTH-1:0] sh_out;
    logic [WIDTH-1:0] add_out;
    logic [WIDTH-1:0] lg_out;
    logic [WIDTH-1:0] slt_out;
    add_flags_t       add_fl;

    assign cls = fclass_e'(fclass);

    // Shift amount: constant field or low bits of the first operand.
    assign amt = amt_var ? x[AMT_W-1:0] : shamt_k;

    alu_shifter #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shift (
        .din  (y),
        .amt  (amt),
        .fn   (shift_fn_e'(shift_fn)),
        .dout (sh_out)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a     (x),
        .b     (y),
        .sub   (sub_sel),
        .sum   (add_out),
        .flags (add_fl)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a    (x),
        .b    (y),
        .fn   (logic_fn_e'(logic_fn)),
        .dout (lg_out)
    );

    assign slt_out = {{(WIDTH-1){1'b0}}, true_less(add_fl)};

    always_comb begin
        unique case (cls)
            FC_SHIFT: result = sh_out;
            FC_SLT:   result = slt_out;
            FC_ARITH: result = add_out;
            FC_LOGIC: result = lg_out;
            default:  result = '0;
        endcase
    end

    assign zero = ~|result;
    assign ovfl = add_fl.ovfl;

    always_comb begin
        // R7: set-less-than drives only bit 0
        a_r7_slt_upper: assert (!(cls == FC_SLT) || (result[WIDTH-1:1] == '0))
            else $error("set-less-than drove upper bits");
        // R8: in set-less-than the zero flag is the inverse of bit 0
        a_r8_zero_slt: assert (!(cls == FC_SLT) || (zero == !result[0]))
            else $error("zero flag disagrees with comparison");
        // R8: a set zero flag never coexists with a set result top bit
        a_r8_zero_msb: assert (!zero || !result[WIDTH-1])
            else $error("zero flag with nonzero result");
    end

endmodule

// File: tb/sim_alu_core.sv
`timescale 1ns/100ps
module sim_alu_core;

    localparam int W     = 32;
    localparam int NV    = 30;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic [31:0] x, y;
    logic [4:0]  shamt_k;
    logic        amt_var, sub_sel;
    logic [1:0]  fclass, logic_fn, shift_fn;
    logic [31:0] result;
    logic        zero, ovfl;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    alu_core u0 (
        .x(x), .y(y), .shamt_k(shamt_k), .amt_var(amt_var),
        .fclass(fclass), .sub_sel(sub_sel), .logic_fn(logic_fn),
        .shift_fn(shift_fn), .result(result), .zero(zero), .ovfl(ovfl)
    );

    // Row: {tag4, x32, y32, shamt5, var1, class2, sub1, lfn2, sfn2, res32, zero1, ovfl1}
    localparam logic [114:0] VEC [NV] = '{
        // R2 add and subtract
        {4'd2, 32'h5, 32'h7, 5'd0, 1'b0, 2'b10, 1'b0, 2'b00, 2'b00, 32'hC, 1'b0, 1'b0},
        {4'd2, 32'h5, 32'h7, 5'd0, 1'b0, 2'b10, 1'b1, 2'b00, 2'b00, 32'hFFFFFFFE, 1'b0, 1'b0},
        // R8 zero from a difference
        {4'd8, 32'h1234, 32'h1234, 5'd0, 1'b0, 2'b10, 1'b1, 2'b00, 2'b00, 32'h0, 1'b1, 1'b0},
        // R3 overflow on add, on subtract, and while logic class is chosen
        {4'd3, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0, 2'b10, 1'b0, 2'b00, 2'b00, 32'h80000000, 1'b0, 1'b1},
        {4'd3, 32'h80000000, 32'h1, 5'd0, 1'b0, 2'b10, 1'b1, 2'b00, 2'b00, 32'h7FFFFFFF, 1'b0, 1'b1},
        {4'd3, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0, 2'b11, 1'b0, 2'b00, 2'b00, 32'h1, 1'b0, 1'b1},
        // R4 logic functions
        {4'd4, 32'hF0F0F0F0, 32'h0FF00FF0, 5'd0, 1'b0, 2'b11, 1'b0, 2'b01, 2'b00, 32'hFFF0FFF0, 1'b0, 1'b0},
        {4'd4, 32'hF0F0F0F0, 32'h0FF00FF0, 5'd0, 1'b0, 2'b11, 1'b0, 2'b10, 2'b00, 32'hFF00FF00, 1'b0, 1'b0},
        {4'd4, 32'hF0F0F0F0, 32'h0FF00FF0, 5'd0, 1'b0, 2'b11, 1'b0, 2'b11, 2'b00, 32'h000F000F, 1'b0, 1'b0},
        {4'd4, 32'hF0F0F0F0, 32'h0FF00FF0, 5'd0, 1'b0, 2'b11, 1'b0, 2'b00, 2'b00, 32'h00F000F0, 1'b0, 1'b0},
        // R8 zero from logic
        {4'd8, 32'hF0F0F0F0, 32'h0F0F0F0F, 5'd0, 1'b0, 2'b11, 1'b0, 2'b00, 2'b00, 32'h0, 1'b1, 1'b0},
        // R7 signed compare, including overflowing differences
        {4'd7, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 32'h1, 1'b0, 1'b0},
        {4'd7, 32'h1, 32'hFFFFFFFF, 5'd0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 32'h0, 1'b1, 1'b0},
        {4'd7, 32'h80000000, 32'h1, 5'd0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 32'h1, 1'b0, 1'b1},
        {4'd7, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 32'h0, 1'b1, 1'b1},
        {4'd7, 32'h5, 32'h5, 5'd0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 32'h0, 1'b1, 1'b0},
        // R5 shift kinds
        {4'd5, 32'h0, 32'h1, 5'd31, 1'b0, 2'b00, 1'b0, 2'b00, 2'b01, 32'h80000000, 1'b0, 1'b0},
        {4'd5, 32'h0, 32'h80000000, 5'd4, 1'b0, 2'b00, 1'b0, 2'b00, 2'b10, 32'h08000000, 1'b0, 1'b0},
        {4'd5, 32'h0, 32'h80000000, 5'd4, 1'b0, 2'b00, 1'b0, 2'b00, 2'b11, 32'hF8000000, 1'b0, 1'b0},
        {4'd5, 32'h0, 32'h12345678, 5'd7, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 32'h12345678, 1'b0, 1'b0},
        {4'd5, 32'h0, 32'h7FFFFFFF, 5'd31, 1'b0, 2'b00, 1'b0, 2'b00, 2'b11, 32'h0, 1'b1, 1'b0},
        // R6 amount source
        {4'd6, 32'h24, 32'h80000000, 5'd0, 1'b1, 2'b00, 1'b0, 2'b00, 2'b11, 32'hF8000000, 1'b0, 1'b0},
        {4'd6, 32'hFFFFFFE3, 32'h10, 5'd9, 1'b1, 2'b00, 1'b0, 2'b00, 2'b01, 32'h80, 1'b0, 1'b0},
        {4'd6, 32'h1F, 32'h10, 5'd2, 1'b0, 2'b00, 1'b0, 2'b00, 2'b10, 32'h4, 1'b0, 1'b0},
        // R9 upper-half immediate placement
        {4'd9, 32'h0, 32'h0000ABCD, 5'd16, 1'b0, 2'b00, 1'b0, 2'b00, 2'b01, 32'hABCD0000, 1'b0, 1'b0},
        {4'd9, 32'h0, 32'hFFFF8001, 5'd16, 1'b0, 2'b00, 1'b0, 2'b00, 2'b01, 32'h80010000, 1'b0, 1'b0},
        // R1 same operands through all four classes
        {4'd1, 32'h3, 32'h5, 5'd1, 1'b0, 2'b00, 1'b1, 2'b01, 2'b01, 32'hA, 1'b0, 1'b0},
        {4'd1, 32'h3, 32'h5, 5'd1, 1'b0, 2'b01, 1'b1, 2'b01, 2'b01, 32'h1, 1'b0, 1'b0},
        {4'd1, 32'h3, 32'h5, 5'd1, 1'b0, 2'b10, 1'b1, 2'b01, 2'b01, 32'hFFFFFFFE, 1'b0, 1'b0},
        {4'd1, 32'h3, 32'h5, 5'd1, 1'b0, 2'b11, 1'b1, 2'b01, 2'b01, 32'h7, 1'b0, 1'b0}
    };

    task automatic compare(input int tag, input logic [31:0] er,
                           input logic ez, input logic eo);
        n_chk++;
        if (result !== er || zero !== ez || ovfl !== eo) begin
            n_err++;
            $display("FAIL R%0d: result=%h zero=%b ovfl=%b expected result=%h zero=%b ovfl=%b",
                     tag, result, zero, ovfl, er, ez, eo);
        end
    endtask

    task automatic drive(input logic [31:0] vx, input logic [31:0] vy,
                         input logic [4:0] vs, input logic vv, input logic [1:0] vc,
                         input logic vsub, input logic [1:0] vl, input logic [1:0] vf);
        @(posedge clk);
        x = vx; y = vy; shamt_k = vs; amt_var = vv;
        fclass = vc; sub_sel = vsub; logic_fn = vl; shift_fn = vf;
        @(negedge clk);
    endtask

    initial begin
        x = '0; y = '0; shamt_k = '0; amt_var = 1'b0;
        fclass = 2'b00; sub_sel = 1'b0; logic_fn = 2'b00; shift_fn = 2'b00;
        @(negedge clk);
        // R8: idle inputs give a zero result and set flag
        compare(8, 32'h0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [114:0] v;
            v = VEC[i];
            drive(v[110:79], v[78:47], v[46:42], v[41], v[40:39], v[38], v[37:36], v[35:34]);
            compare(int'(v[114:111]), v[33:2], v[1], v[0]);
        end

        // R5 and R6: every amount and every shift kind, alternating amount source
        for (int a = 0; a < 32; a++) begin
            for (int f = 1; f < 4; f++) begin
                logic [31:0] vy, vx, exp_r;
                logic        use_var;
                vy      = 32'h87654321;
                use_var = a[0];
                vx      = use_var ? (32'h5A5A5A40 | 32'(a)) : 32'h0;
                if (f == 1)      exp_r = vy << a;
                else if (f == 2) exp_r = vy >> a;
                else             exp_r = 32'($signed(vy) >>> a);
                drive(vx, vy, use_var ? 5'(31 - a) : 5'(a), use_var, 2'b00, 1'b0, 2'b00, 2'(f));
                compare(5, exp_r, exp_r == 32'h0, 1'b0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run exceeded %0d cycles", LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule